// File: doc/BRIEF.md
# PLL Mode and Divider Controller

This block decides how the system clock is derived from the oscillator clock. Software-style writes load a multiplier value, a two-bit divider select and a power-off bit. From these the controller works out which of three modes the clock path is in: off (PLL unpowered, reference passed straight through), bypass (PLL powered, reference passed straight through) or enabled (reference multiplied by the PLL). It drives the PLL power enable and the select line that picks the PLL output over the bypass path. It also reports the multiply and divide ratios currently in force.

The analog PLL has no lock indication in this model. A lock timer counts a programmable number of reference cycles in its place. Every accepted multiplier write restarts that count, including a write of the value already held. Until the count completes, the clock path is held on the bypass route. The power-off bit is guarded so that the PLL can only be shut down once the multiplier has been returned to zero. Requests that break this ordering are dropped and recorded in a sticky error flag. Everything is synchronous to a free-running reference clock.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After reset the multiplier register is zero, the divider select is 0 (divide by 4), the power-off bit and the error flag are clear, mode_o is bypass (encoding 1), pll_pwr_en is 1, pll_sel is 0 and mult_o is 1.
- R2: While the multiplier register holds zero and power-off is clear, mode_o is bypass, pll_pwr_en is 1, pll_sel is 0 and mult_o is 1, even once locked_o is high.
- R3: With a nonzero multiplier n, power-off clear and the lock count complete, mode_o is enabled (encoding 2), pll_sel is 1 and mult_o equals n.
- R4: Every accepted multiplier write restarts the lock count, even when it rewrites the value already held. After such a write at clock edge E, locked_o is low and the path is in bypass from E onward, and locked_o rises at edge E+L, where L is the lock_cycles input (L >= 1).
- R5: div_o reports the divide ratio as a number. Divider select values 0 and 1 give 4, value 2 gives 2 and value 3 gives 1. A divider write takes effect in every mode and does not restart the lock count.
- R6: A power-off write with value 1, made while the multiplier register is zero, enters off mode (encoding 0). In off mode pll_pwr_en is 0, pll_sel is 0, locked_o is 0 and mult_o is 1.
- R7: A power-off write with value 1, made while the multiplier register is nonzero, is ignored and sets pwroff_err. pwroff_err stays set until reset.
- R8: A multiplier write made while off mode holds, or in the same cycle that off mode is entered, is ignored and sets pwroff_err.
- R9: A power-off write with value 0 leaves off mode for bypass and restarts the lock count. locked_o rises L edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_cycles | input | CNT_W | Reference cycles the lock wait lasts |
| mult_we | input | 1 | Multiplier write strobe |
| mult_wdata | input | MULT_W | Multiplier value to write |
| div_we | input | 1 | Divider select write strobe |
| div_wdata | input | 2 | Divider select value to write |
| pwroff_we | input | 1 | Power-off bit write strobe |
| pwroff_wdata | input | 1 | Power-off bit value to write |
| mode_o | output | 2 | Current mode: 0 off, 1 bypass, 2 enabled |
| mult_o | output | MULT_W | Multiply ratio in force (1 unless enabled) |
| div_o | output | 3 | Divide ratio in force: 4, 2 or 1 |
| pll_pwr_en | output | 1 | PLL power enable |
| pll_sel | output | 1 | 1 selects the PLL output, 0 the bypass path |
| locked_o | output | 1 | Lock count complete |
| pwroff_err | output | 1 | Sticky flag for rejected out-of-order writes |

## Verification
The embedded properties check, on every cycle, that off mode never coexists with a nonzero multiplier and that the PLL path is chosen only while powered and locked. They also check that every multiplier write drops the path to bypass on the next edge, that a rejected power-off leaves the mode untouched, that the divide ratio is always a single power of two, and that the error flag never clears. Only the directed scenarios can show the exact lock latency for different lock_cycles values, and the restart on a rewrite of an unchanged value. The same holds for the ratio mapping for each select value and for the fact that a multiplier write dropped in off mode leaves the register at zero, which is seen once off mode has been left.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_BYPASS  = 2'd1,
        MODE_ENABLED = 2'd2
    } pll_mode_e;
endpackage

// File: rtl/pll_div_decode.sv
module pll_div_decode #(
    parameter int SEL_W   = 2,
    parameter int RATIO_W = 3
) (
    input  logic [SEL_W-1:0]   sel,
    output logic [RATIO_W-1:0] ratio
);
    localparam int NSEL = 1 << SEL_W;

    logic [RATIO_W-1:0] table_w [NSEL];

    // Codes below 2 share the slowest ratio; code k >= 2 divides by 2^(NSEL-1-k).
    for (genvar k = 0; k < NSEL; k++) begin : g_ratio
        if (k < 2) begin : g_low
            assign table_w[k] = RATIO_W'(1 << (NSEL - 2));
        end else begin : g_high
            assign table_w[k] = RATIO_W'(1 << (NSEL - 1 - k));
        end
    end

    assign ratio = table_w[sel];
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             restart,
    input  logic [CNT_W-1:0] lock_cycles,
    output logic             locked
);
    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             locked;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic [EXT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + EXT_W'(1);
        if (hold || restart) begin
            st_d.cnt    = '0;
            st_d.locked = 1'b0;
        end else if (!st_q.locked) begin
            st_d.cnt    = cnt_inc[CNT_W-1:0];
            st_d.locked = (cnt_inc >= {1'b0, lock_cycles});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;

    // R4
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !locked);

    // R6
    hold_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !locked);
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
    import pll_mode_pkg::*;
#(
    parameter int MULT_W = 7,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  lock_cycles,
    input  logic              mult_we,
    input  logic [MULT_W-1:0] mult_wdata,
    input  logic              div_we,
    input  logic [1:0]        div_wdata,
    input  logic              pwroff_we,
    input  logic              pwroff_wdata,
    output logic [1:0]        mode_o,
    output logic [MULT_W-1:0] mult_o,
    output logic [2:0]        div_o,
    output logic              pll_pwr_en,
    output logic              pll_sel,
    output logic              locked_o,
    output logic              pwroff_err
);
    localparam int SEL_W   = 2;
    localparam int RATIO_W = 3;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [SEL_W-1:0]  div_sel;
        logic              pwroff;
        logic              err;
    } ctrl_st_t;

    ctrl_st_t  st_d, st_q;
    logic      restart_d;
    logic      locked_w;
    pll_mode_e mode_w;

    always_comb begin
        st_d      = st_q;
        restart_d = 1'b0;
        if (pwroff_we) begin
            if (!pwroff_wdata)            st_d.pwroff = 1'b0;
            else if (st_q.mult == '0)     st_d.pwroff = 1'b1;
            else                          st_d.err    = 1'b1;
        end
        if (mult_we) begin
            if (st_q.pwroff || st_d.pwroff) begin
                st_d.err = 1'b1;
            end else begin
                st_d.mult = mult_wdata;
                restart_d = 1'b1;
            end
        end
        if (st_q.pwroff && !st_d.pwroff) restart_d = 1'b1;
        if (div_we) st_d.div_sel = div_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pll_lock_timer #(.CNT_W(CNT_W)) lock_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (st_d.pwroff),
        .restart     (restart_d),
        .lock_cycles (lock_cycles),
        .locked      (locked_w)
    );

    pll_div_decode #(.SEL_W(SEL_W), .RATIO_W(RATIO_W)) div_i (
        .sel   (st_q.div_sel),
        .ratio (div_o)
    );

    always_comb begin
        if (st_q.pwroff)                        mode_w = MODE_OFF;
        else if (st_q.mult != '0 && locked_w)   mode_w = MODE_ENABLED;
        else                                    mode_w = MODE_BYPASS;
    end

    assign mode_o     = mode_w;
    assign pll_sel    = (mode_w == MODE_ENABLED);
    assign pll_pwr_en = !st_q.pwroff;
    assign mult_o     = (mode_w == MODE_ENABLED) ? st_q.mult : MULT_W'(1);
    assign locked_o   = locked_w;
    assign pwroff_err = st_q.err;

    // R6
    off_mult_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_OFF) |-> (st_q.mult == '0));

    // R3
    sel_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_sel |-> (locked_o && pll_pwr_en));

    // R4
    relock_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_we && mode_o != MODE_OFF) |=> (!pll_sel && !locked_o));

    // R7
    pwroff_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwroff_we && pwroff_wdata && mode_o != MODE_OFF && st_q.mult != '0)
        |=> (mode_o != MODE_OFF && pwroff_err));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwroff_err |=> pwroff_err);

    // R5
    div_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(div_o) == 1);
endmodule

// File: tb/pll_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pll_mode_ctrl_tb_top;
    localparam int MULT_W = 7;
    localparam int CNT_W  = 16;
    localparam int L      = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [CNT_W-1:0]  lock_cycles;
    logic              mult_we, div_we, pwroff_we, pwroff_wdata;
    logic [MULT_W-1:0] mult_wdata;
    logic [1:0]        div_wdata;
    logic [1:0]        mode_o;
    logic [MULT_W-1:0] mult_o;
    logic [2:0]        div_o;
    logic              pll_pwr_en, pll_sel, locked_o, pwroff_err;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pll_mode_ctrl #(.MULT_W(MULT_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .lock_cycles(lock_cycles),
        .mult_we(mult_we), .mult_wdata(mult_wdata),
        .div_we(div_we), .div_wdata(div_wdata),
        .pwroff_we(pwroff_we), .pwroff_wdata(pwroff_wdata),
        .mode_o(mode_o), .mult_o(mult_o), .div_o(div_o),
        .pll_pwr_en(pll_pwr_en), .pll_sel(pll_sel),
        .locked_o(locked_o), .pwroff_err(pwroff_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr_mult(input int v);
        mult_we = 1'b1; mult_wdata = MULT_W'(v);
        @(negedge clk);
        mult_we = 1'b0;
    endtask

    task automatic wr_div(input int v);
        div_we = 1'b1; div_wdata = 2'(v);
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic wr_off(input bit v);
        pwroff_we = 1'b1; pwroff_wdata = v;
        @(negedge clk);
        pwroff_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "mode", mode_o, 1);
        chk("R1", "div", div_o, 4);
        chk("R1", "mult", mult_o, 1);
        chk("R1", "pwr_en", pll_pwr_en, 1);
        chk("R1", "sel", pll_sel, 0);
        chk("R1", "err", pwroff_err, 0);
        idle(L);
        chk("R2", "locked", locked_o, 1);
        chk("R2", "mode with zero mult", mode_o, 1);
        chk("R2", "sel", pll_sel, 0);
        chk("R2", "mult", mult_o, 1);
    endtask

    task automatic t_enable();
        wr_mult(5);
        chk("R4", "bypass after write", mode_o, 1);
        chk("R4", "locked after write", locked_o, 0);
        idle(L - 1);
        chk("R4", "still bypass at L-1", pll_sel, 0);
        idle(1);
        chk("R3", "mode", mode_o, 2);
        chk("R3", "sel", pll_sel, 1);
        chk("R3", "mult", mult_o, 5);
    endtask

    task automatic t_rewrite();
        wr_mult(5);
        chk("R4", "same value drops to bypass", mode_o, 1);
        idle(L - 1);
        chk("R4", "same value unlocked at L-1", locked_o, 0);
        idle(1);
        chk("R4", "same value relocks at L", mode_o, 2);
    endtask

    task automatic t_div();
        wr_div(1); chk("R5", "sel1", div_o, 4);
        wr_div(2); chk("R5", "sel2", div_o, 2);
        wr_div(3); chk("R5", "sel3", div_o, 1);
        wr_div(0); chk("R5", "sel0", div_o, 4);
        chk("R5", "no relock on div write", mode_o, 2);
    endtask

    task automatic t_reject();
        wr_off(1'b1);
        chk("R7", "mode unchanged", mode_o, 2);
        chk("R7", "pwr_en", pll_pwr_en, 1);
        chk("R7", "err set", pwroff_err, 1);
        wr_mult(0);
        chk("R2", "zero mult bypass", mode_o, 1);
        idle(L + 1);
        chk("R2", "zero mult stays bypass", mode_o, 1);
        chk("R7", "err sticky", pwroff_err, 1);
    endtask

    task automatic t_off();
        wr_off(1'b1);
        chk("R6", "mode", mode_o, 0);
        chk("R6", "pwr_en", pll_pwr_en, 0);
        chk("R6", "sel", pll_sel, 0);
        chk("R6", "locked", locked_o, 0);
        chk("R6", "mult", mult_o, 1);
        wr_div(2);
        chk("R5", "div in off", div_o, 2);
        wr_mult(7);
        chk("R8", "off kept", mode_o, 0);
        wr_off(1'b0);
        chk("R9", "back to bypass", mode_o, 1);
        chk("R9", "locked restarted", locked_o, 0);
        idle(L - 1);
        chk("R9", "unlocked at L-1", locked_o, 0);
        idle(1);
        chk("R9", "locked at L", locked_o, 1);
        chk("R8", "mult write dropped", mode_o, 1);
        chk("R8", "mult stays 1", mult_o, 1);
    endtask

    task automatic t_short_lock();
        lock_cycles = CNT_W'(1);
        wr_mult(3);
        chk("R4", "L=1 bypass", mode_o, 1);
        idle(1);
        chk("R4", "L=1 enabled", mode_o, 2);
        chk("R3", "L=1 mult", mult_o, 3);
        chk("R5", "ratio kept", div_o, 2);
    endtask

    initial begin
        rst_n = 1'b0; lock_cycles = CNT_W'(L);
        mult_we = 0; mult_wdata = '0; div_we = 0; div_wdata = '0;
        pwroff_we = 0; pwroff_wdata = 0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_rewrite();
        t_div();
        t_reject();
        t_off();
        t_short_lock();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule